// File: doc/BRIEF.md
# Receive Line Idle-Resync and Break Guard

This block sits beside the frame decoder of an asynchronous serial receiver and watches the synchronized receive line. It keeps a resynchronization state that holds reception off until the line has stayed high for a set number of bit periods. A system reset, a software reset, entry to low-power mode, or handing the receive pin to general-purpose use sends it back into that state. While it is there, a qualifier output tells the character assembler to take no data.

The block also detects a break: a low line that persists after the decoder reports a missing stop bit. The break flag is sticky. Software clears it by writing 1 to the flag bit or by reading the interrupt-vector slot that belongs to it, and the reset sources also clear it. An error interrupt request is a level equal to the flag gated by its enable. Bit-period ticks come from the baud generator, and both counters advance only on those ticks.

Top module: `rxs_line_guard`

## Requirements
- R1: `idle_flag` reads 1 in the cycle after any of `rst`, `sw_rst`, `pwr_down` or `rx_gpio_sel` is high; 1 means that no idle period has been seen yet.
- R2: `rx_enable` is 0 whenever `idle_flag` is 1, and is 1 once `idle_flag` is 0.
- R3: `idle_flag` goes to 0 on the clock edge that samples the IDLE_BITS-th (default 11) consecutive `bit_tick` with `rx_level` high, and not earlier.
- R4: Any cycle with `rx_level` low, before the idle count completes, restarts the idle count from zero.
- R5: After a `frame_err` pulse, `brk_flag` becomes 1 on the clock edge that samples the BREAK_BITS-th (default 10) `bit_tick` with `rx_level` held low since the pulse.
- R6: No break is flagged if `rx_level` goes high before that count completes, or if no `frame_err` pulse preceded the low run.
- R7: Clock cycles without `bit_tick` do not advance the break low-run count.
- R8: Once set, `brk_flag` stays 1 until one of its clear conditions occurs.
- R9: `brk_flag` clears on a cycle with `clr_wr`=1 and `clr_wdata`=1, or with `vec_rd`=1; a write with `clr_wdata`=0 has no effect.
- R10: `brk_flag` clears on `rst`, `sw_rst` or `mod_rst`.
- R11: When a break set and a clear by write or vector read fall in the same cycle, `brk_flag` becomes 1.
- R12: `err_irq` equals `brk_flag` AND `brk_ie` at all times, so it drops in the cycle the flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | System reset, synchronous, active high |
| sw_rst | input | 1 | Software reset of the serial unit |
| mod_rst | input | 1 | Module reset (clears the break flag only) |
| pwr_down | input | 1 | Low-power entry request |
| rx_gpio_sel | input | 1 | Receive pin assigned to general-purpose I/O |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| rx_level | input | 1 | Synchronized receive line level |
| frame_err | input | 1 | Missing-stop-bit pulse from the frame decoder |
| brk_ie | input | 1 | Break interrupt enable |
| clr_wr | input | 1 | Write strobe for the break flag bit |
| clr_wdata | input | 1 | Write data for the break flag bit (1 clears) |
| vec_rd | input | 1 | Read of the break slot in the interrupt vector |
| idle_flag | output | 1 | 1 = waiting for idle period, reception blocked |
| rx_enable | output | 1 | Receive qualifier for the character assembler |
| brk_flag | output | 1 | Sticky break indication |
| err_irq | output | 1 | Error interrupt request level |

## Verification
The bench builds the block with its default counts, 11 idle bit periods and 10 low bit periods. At these sizes every terminal count can be reached in a few tens of ticks, so the tests go one tick short of each threshold and then exactly to it. They also cover a restart at 10 of 11 ticks, a break abandoned part way through, and a write-1 clear that lands on the same edge as the tenth low tick. Long stretches with no ticks are also small enough to drive, which shows that only ticks advance the counts.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    typedef enum logic [1:0] {
        BW_IDLE  = 2'd0,
        BW_ARMED = 2'd1,
        BW_DONE  = 2'd2
    } bw_state_e;

    typedef struct packed {
        logic sys;
        logic sw;
        logic mod;
        logic pdn;
        logic gpio;
    } rst_src_t;

    typedef struct packed {
        logic wr;
        logic wdata;
        logic vec_rd;
    } clr_req_t;

    // Sources that put the receiver back into the idle-resync state
    function automatic logic idle_force(input rst_src_t s);
        return s.sys | s.sw | s.pdn | s.gpio;
    endfunction

    // Sources that wipe break detection state and the sticky flag
    function automatic logic brk_reset(input rst_src_t s);
        return s.sys | s.sw | s.mod;
    endfunction

    // Software-initiated clear of the break flag
    function automatic logic sw_clear(input clr_req_t c);
        return (c.wr & c.wdata) | c.vec_rd;
    endfunction

endpackage

// File: rtl/rxs_idle_sync.sv
module rxs_idle_sync #(
    parameter int IDLE_BITS = 11
) (
    input  logic clk,
    input  logic force_idle,
    input  logic bit_tick,
    input  logic rx_level,
    output logic idle_flag,
    output logic rx_enable
);
    localparam int CW = $clog2(IDLE_BITS + 1);
    localparam logic [CW-1:0] LAST = CW'(IDLE_BITS - 1);

    logic [CW-1:0] run_cnt;
    logic          waiting;

    always_ff @(posedge clk) begin
        if (force_idle) begin
            waiting <= 1'b1;
            run_cnt <= '0;
        end else if (waiting) begin
            if (!rx_level) begin
                run_cnt <= '0;
            end else if (bit_tick) begin
                if (run_cnt == LAST) begin
                    waiting <= 1'b0;
                    run_cnt <= '0;
                end else begin
                    run_cnt <= run_cnt + 1'b1;
                end
            end
        end
    end

    assign idle_flag = waiting;
    assign rx_enable = ~waiting;

    // R1: every idle source forces the waiting state
    assert_force_idle_R1: assert property (@(posedge clk)
        force_idle |=> waiting);

    // R3: counter never passes its terminal value
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (force_idle)
        run_cnt < CW'(IDLE_BITS));

    // R3: leaving the idle state needs a high-line tick
    assert_exit_on_tick_R3: assert property (@(posedge clk) disable iff (force_idle)
        $fell(waiting) |-> $past(bit_tick && rx_level));

    // R4: a low line leaves the count at zero
    assert_low_restart_R4: assert property (@(posedge clk) disable iff (force_idle)
        (waiting && !rx_level) |=> (run_cnt == '0));

endmodule

// File: rtl/rxs_break_watch.sv
module rxs_break_watch
    import rxs_pkg::*;
#(
    parameter int BREAK_BITS = 10
) (
    input  logic clk,
    input  logic clr_state,
    input  logic bit_tick,
    input  logic rx_level,
    input  logic frame_err,
    output logic brk_set
);
    localparam int CW = $clog2(BREAK_BITS + 1);
    localparam logic [CW-1:0] LAST = CW'(BREAK_BITS - 1);

    bw_state_e     state;
    logic [CW-1:0] low_cnt;

    always_comb begin
        brk_set = (state == BW_ARMED) && !rx_level && bit_tick &&
                  !frame_err && !clr_state && (low_cnt == LAST);
    end

    always_ff @(posedge clk) begin
        if (clr_state) begin
            state   <= BW_IDLE;
            low_cnt <= '0;
        end else if (frame_err) begin
            state   <= BW_ARMED;
            low_cnt <= '0;
        end else begin
            unique case (state)
                BW_ARMED: begin
                    if (rx_level) begin
                        state   <= BW_IDLE;
                        low_cnt <= '0;
                    end else if (bit_tick) begin
                        if (low_cnt == LAST) begin
                            state   <= BW_DONE;
                            low_cnt <= '0;
                        end else begin
                            low_cnt <= low_cnt + 1'b1;
                        end
                    end
                end
                BW_DONE: begin
                    if (rx_level) state <= BW_IDLE;
                end
                default: begin
                    state   <= BW_IDLE;
                    low_cnt <= '0;
                end
            endcase
        end
    end

    // R7: cycles without a tick leave the low-run count unchanged
    assert_tick_only_R7: assert property (@(posedge clk) disable iff (clr_state)
        (state == BW_ARMED && !bit_tick && !frame_err && !rx_level) |=> (low_cnt == $past(low_cnt)));

    // R6: a high line abandons an armed run
    assert_abandon_R6: assert property (@(posedge clk) disable iff (clr_state)
        (state == BW_ARMED && rx_level && !frame_err) |=> (state == BW_IDLE));

    // R5: a detected break parks the tracker until the line rises
    assert_done_after_set_R5: assert property (@(posedge clk) disable iff (clr_state)
        brk_set |=> (state == BW_DONE));

endmodule

// File: rtl/rxs_break_flag.sv
module rxs_break_flag
    import rxs_pkg::*;
(
    input  logic     clk,
    input  logic     clr_state,
    input  logic     set_evt,
    input  clr_req_t clr_req,
    input  logic     irq_en,
    output logic     flag,
    output logic     irq
);
    logic sticky;
    logic sw_clr;

    assign sw_clr = sw_clear(clr_req);

    always_ff @(posedge clk) begin
        if (clr_state)    sticky <= 1'b0;
        else if (set_evt) sticky <= 1'b1;
        else if (sw_clr)  sticky <= 1'b0;
    end

    assign flag = sticky;
    assign irq  = sticky & irq_en;

    // R8: flag holds without a clear request
    assert_sticky_R8: assert property (@(posedge clk) disable iff (clr_state)
        (sticky && !clr_req.vec_rd && !(clr_req.wr && clr_req.wdata)) |=> sticky);

    // R11: a set event lands even with a clear in the same cycle
    assert_set_wins_R11: assert property (@(posedge clk) disable iff (clr_state)
        set_evt |=> sticky);

    // R9: clear request without a set empties the flag
    assert_sw_clear_R9: assert property (@(posedge clk) disable iff (clr_state)
        (sw_clr && !set_evt) |=> !sticky);

endmodule

// File: rtl/rxs_line_guard.sv
module rxs_line_guard
    import rxs_pkg::*;
#(
    parameter int IDLE_BITS  = 11,
    parameter int BREAK_BITS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic sw_rst,
    input  logic mod_rst,
    input  logic pwr_down,
    input  logic rx_gpio_sel,
    input  logic bit_tick,
    input  logic rx_level,
    input  logic frame_err,
    input  logic brk_ie,
    input  logic clr_wr,
    input  logic clr_wdata,
    input  logic vec_rd,
    output logic idle_flag,
    output logic rx_enable,
    output logic brk_flag,
    output logic err_irq
);
    rst_src_t src;
    clr_req_t clr;
    logic     force_idle;
    logic     brk_clr;
    logic     brk_set;

    always_comb begin
        src.sys    = rst;
        src.sw     = sw_rst;
        src.mod    = mod_rst;
        src.pdn    = pwr_down;
        src.gpio   = rx_gpio_sel;
        clr.wr     = clr_wr;
        clr.wdata  = clr_wdata;
        clr.vec_rd = vec_rd;
        force_idle = idle_force(src);
        brk_clr    = brk_reset(src);
    end

    rxs_idle_sync #(.IDLE_BITS(IDLE_BITS)) u_idle (
        .clk        (clk),
        .force_idle (force_idle),
        .bit_tick   (bit_tick),
        .rx_level   (rx_level),
        .idle_flag  (idle_flag),
        .rx_enable  (rx_enable)
    );

    rxs_break_watch #(.BREAK_BITS(BREAK_BITS)) u_watch (
        .clk       (clk),
        .clr_state (brk_clr),
        .bit_tick  (bit_tick),
        .rx_level  (rx_level),
        .frame_err (frame_err),
        .brk_set   (brk_set)
    );

    rxs_break_flag u_flag (
        .clk       (clk),
        .clr_state (brk_clr),
        .set_evt   (brk_set),
        .clr_req   (clr),
        .irq_en    (brk_ie),
        .flag      (brk_flag),
        .irq       (err_irq)
    );

    // R2: reception opens only on a high-line tick
    assert_enable_rise_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_enable) |-> $past(bit_tick && rx_level));

    // R5: a break is only raised on a low-line tick
    assert_break_on_low_tick_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(brk_flag) |-> $past(bit_tick && !rx_level));

    // R10: reset sources leave the break flag cleared
    assert_reset_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (sw_rst || mod_rst) |=> !brk_flag);

    // R12: request falls together with the flag
    assert_irq_drop_R12: assert property (@(posedge clk) disable iff (rst)
        $fell(brk_flag) |-> !err_irq);

endmodule

// File: tb/sim_rxs_line_guard.sv
module sim_rxs_line_guard;
    localparam int CLK_PERIOD = 10;
    localparam int IDLE_N     = 11;
    localparam int BRK_N      = 10;

    logic clk = 1'b0;
    logic rst = 1'b1, sw_rst = 1'b0, mod_rst = 1'b0, pwr_down = 1'b0, rx_gpio_sel = 1'b0;
    logic bit_tick = 1'b0, rx_level = 1'b1, frame_err = 1'b0, brk_ie = 1'b0;
    logic clr_wr = 1'b0, clr_wdata = 1'b0, vec_rd = 1'b0;
    logic idle_flag, rx_enable, brk_flag, err_irq;

    int total = 0;
    int fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rxs_line_guard #(.IDLE_BITS(IDLE_N), .BREAK_BITS(BRK_N)) u0 (
        .clk(clk), .rst(rst), .sw_rst(sw_rst), .mod_rst(mod_rst), .pwr_down(pwr_down),
        .rx_gpio_sel(rx_gpio_sel), .bit_tick(bit_tick), .rx_level(rx_level),
        .frame_err(frame_err), .brk_ie(brk_ie), .clr_wr(clr_wr), .clr_wdata(clr_wdata),
        .vec_rd(vec_rd), .idle_flag(idle_flag), .rx_enable(rx_enable),
        .brk_flag(brk_flag), .err_irq(err_irq)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic tick(input logic lvl);
        @(negedge clk);
        rx_level = lvl;
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
    endtask

    task automatic hold(input logic lvl, input int n);
        @(negedge clk);
        rx_level = lvl;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ferr();
        @(negedge clk);
        rx_level  = 1'b0;
        frame_err = 1'b1;
        @(negedge clk);
        frame_err = 1'b0;
    endtask

    task automatic pulse_sw_rst();
        @(negedge clk); sw_rst = 1'b1;
        @(negedge clk); sw_rst = 1'b0;
    endtask

    task automatic wr_flag(input logic d);
        @(negedge clk); clr_wr = 1'b1; clr_wdata = d;
        @(negedge clk); clr_wr = 1'b0; clr_wdata = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle after reset", idle_flag, 1'b1);
        chk("R2 enable off after reset", rx_enable, 1'b0);
        chk("R10 break clear after reset", brk_flag, 1'b0);
        chk("R12 irq low after reset", err_irq, 1'b0);
    endtask

    task automatic t_idle_sync();
        for (int i = 0; i < IDLE_N - 1; i++) tick(1'b1);
        chk("R3 idle held one tick short", idle_flag, 1'b1);
        chk("R2 enable off while idle", rx_enable, 1'b0);
        hold(1'b1, 20);
        chk("R3 no ticks no progress", idle_flag, 1'b1);
        tick(1'b1);
        chk("R3 idle clears at count", idle_flag, 1'b0);
        chk("R2 enable on", rx_enable, 1'b1);
        hold(1'b0, 3);
        chk("R3 low line does not re-idle", idle_flag, 1'b0);
        hold(1'b1, 1);
    endtask

    task automatic t_idle_restart();
        pulse_sw_rst();
        chk("R1 idle after software reset", idle_flag, 1'b1);
        for (int i = 0; i < IDLE_N - 1; i++) tick(1'b1);
        hold(1'b0, 1);
        for (int i = 0; i < IDLE_N - 1; i++) tick(1'b1);
        chk("R4 restart after low", idle_flag, 1'b1);
        tick(1'b1);
        chk("R4 full count after restart", idle_flag, 1'b0);
    endtask

    task automatic t_idle_sources();
        @(negedge clk); pwr_down = 1'b1;
        @(negedge clk); pwr_down = 1'b0;
        chk("R1 idle after power-down", idle_flag, 1'b1);
        for (int i = 0; i < IDLE_N; i++) tick(1'b1);
        chk("R3 resync after power-down", idle_flag, 1'b0);
        @(negedge clk); rx_gpio_sel = 1'b1;
        @(negedge clk); rx_gpio_sel = 1'b0;
        chk("R1 idle after gpio select", idle_flag, 1'b1);
        chk("R2 enable off after gpio select", rx_enable, 1'b0);
    endtask

    task automatic t_break_basic();
        brk_ie = 1'b1;
        ferr();
        for (int i = 0; i < BRK_N - 1; i++) tick(1'b0);
        chk("R5 no break one tick short", brk_flag, 1'b0);
        tick(1'b0);
        chk("R5 break at count", brk_flag, 1'b1);
        chk("R12 irq with enable", err_irq, 1'b1);
        hold(1'b1, 30);
        chk("R8 flag sticky", brk_flag, 1'b1);
        wr_flag(1'b0);
        chk("R9 write 0 no effect", brk_flag, 1'b1);
        wr_flag(1'b1);
        chk("R9 write 1 clears", brk_flag, 1'b0);
        chk("R12 irq follows clear", err_irq, 1'b0);
    endtask

    task automatic t_break_abort();
        ferr();
        for (int i = 0; i < 5; i++) tick(1'b0);
        hold(1'b1, 1);
        for (int i = 0; i < 2 * BRK_N; i++) tick(1'b0);
        chk("R6 abandoned on high line", brk_flag, 1'b0);
        hold(1'b1, 1);
        for (int i = 0; i < 2 * BRK_N; i++) tick(1'b0);
        chk("R6 no framing error no break", brk_flag, 1'b0);
        hold(1'b1, 1);
    endtask

    task automatic t_tick_only();
        ferr();
        hold(1'b0, 100);
        chk("R7 cycles without tick do not count", brk_flag, 1'b0);
        for (int i = 0; i < BRK_N; i++) tick(1'b0);
        chk("R7 ticks complete the run", brk_flag, 1'b1);
        @(negedge clk); vec_rd = 1'b1;
        @(negedge clk); vec_rd = 1'b0;
        chk("R9 vector read clears", brk_flag, 1'b0);
        hold(1'b1, 1);
    endtask

    task automatic t_set_wins();
        ferr();
        for (int i = 0; i < BRK_N - 1; i++) tick(1'b0);
        @(negedge clk);
        bit_tick = 1'b1; clr_wr = 1'b1; clr_wdata = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0; clr_wr = 1'b0; clr_wdata = 1'b0;
        chk("R11 set beats write-1 clear", brk_flag, 1'b1);
        hold(1'b1, 1);
    endtask

    task automatic t_resets_clear();
        pulse_sw_rst();
        chk("R10 software reset clears break", brk_flag, 1'b0);
        ferr();
        for (int i = 0; i < BRK_N; i++) tick(1'b0);
        chk("R5 second break", brk_flag, 1'b1);
        @(negedge clk); mod_rst = 1'b1;
        @(negedge clk); mod_rst = 1'b0;
        chk("R10 module reset clears break", brk_flag, 1'b0);
        hold(1'b1, 1);
    endtask

    task automatic t_irq_enable();
        brk_ie = 1'b0;
        ferr();
        for (int i = 0; i < BRK_N; i++) tick(1'b0);
        chk("R12 flag set with enable off", brk_flag, 1'b1);
        chk("R12 irq masked", err_irq, 1'b0);
        @(negedge clk); brk_ie = 1'b1;
        #1;
        chk("R12 irq on enable", err_irq, 1'b1);
        hold(1'b1, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        t_reset();
        t_idle_sync();
        t_idle_restart();
        t_idle_sources();
        t_break_basic();
        t_break_abort();
        t_tick_only();
        t_set_wins();
        t_resets_clear();
        t_irq_enable();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule